// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Set/Clear Output Control

This block gives software control of up to 128 general-purpose pins over a simple single-cycle read/write bus with 64-bit data. Pin outputs are never written directly. Software sets bits through a write-one-to-set register and clears them through a write-one-to-clear register, so concurrent agents can change separate pins without a read-modify-write. Pin inputs cross into the clock domain through a synchronizer. An optional per-pin inversion is then applied, and the result is held in an input data register that software reads.

Each pin owns a 64-bit configuration word. The word holds an output-enable bit, an input-inversion bit, an interrupt-enable bit and an 11-bit alternate-function select. A nonzero select hands the pin to another function, and the controller then stops driving the pad. A level interrupt is raised while any interrupt-enabled pin reads high after inversion. A read-only register reports the number of implemented pins. Pins 64 and above sit in a second copy of the data, set and clear registers.

Top module: `gpio_regbank`

## Requirements
- R1: While reset is asserted and after it is released, with no writes yet made, pad_out, pad_oe and irq are all zero, and every configuration word reads zero.
- R2: A write to offset 0x08 (pins 0..63) or 0x1408 (pins 64..127) sets the output latch of each pin whose data bit is 1, from the next clock edge. Pins whose data bit is 0 keep their value.
- R3: A write to offset 0x10 (pins 0..63) or 0x1410 (pins 64..127) clears the output latch of each pin whose data bit is 1, from the next clock edge. Pins whose data bit is 0 keep their value.
- R4: Reads return data on bus_rdata one cycle after the request, and hold it until the next read. A read of a set or clear offset returns the current output latch of that pin group, with bit n holding pin n of the group.
- R5: The input data register at 0x00 (pins 0..63) holds the pad input after two synchronizer flops, XORed with the pin's inversion bit. A pad change shows in the register after the third clock edge. Bits for pins that are not implemented read zero.
- R6: Offset 0x90 reads the implemented pin count in bits 7:0, and all other bits read zero.
- R7: The configuration word of pin p sits at 0x400 + 8*p. Bit 0 is output enable, bit 1 is input inversion, bit 2 is interrupt enable, and bits 26:16 are the alternate-function select. Writes store these fields, and all other bits read zero.
- R8: pad_oe[p] is 1 exactly when pin p's output-enable bit is 1 and its alternate-function select is zero. pad_out carries the output latch whatever the ownership.
- R9: irq is 1 exactly when at least one pin has interrupt enable set and a 1 in its input data register bit.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to them, to the input data register or to the count register change no pad output, no configuration and no later read value.
- R11: Offset 0x1400 returns the input data register of pins 64..127. When 64 or fewer pins exist, 0x1400..0x1410 are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid one cycle after a read |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Output latch to pads |
| pad_oe | output | NUM_PINS | Pad output drive enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets a set and a clear aimed at the same pins, where a latch that rewrote whole words would disturb the pins it was not told to touch. It also covers a pin that has output enable set and a nonzero alternate select: a design that ignored the select would still drive the pad. It checks that the inversion bit shifts the input register and the interrupt by exactly one sampling stage, which shows up if the inversion were applied to the sync flops or with the wrong latency. Finally, it probes the second pin group, offsets just past the last configuration word, misaligned offsets and writes to the read-only registers, where a loose decoder would alias them onto real registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   localparam int unsigned WORD_W  = 64;
   localparam int unsigned ADDR_W  = 13;
   localparam int unsigned GROUP_W = 64;

   localparam int unsigned OFS_RX   = 'h000;
   localparam int unsigned OFS_SET  = 'h008;
   localparam int unsigned OFS_CLR  = 'h010;
   localparam int unsigned OFS_CNT  = 'h090;
   localparam int unsigned OFS_CFG  = 'h400;
   localparam int unsigned OFS_HI   = 'h1400;

   localparam int unsigned FB_OE    = 0;
   localparam int unsigned FB_INV   = 1;
   localparam int unsigned FB_IE    = 2;
   localparam int unsigned FB_SEL   = 16;
   localparam int unsigned SEL_W    = 11;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_RX,
      ACC_SET,
      ACC_CLR,
      ACC_CNT,
      ACC_CFG
   } acc_kind_t;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             ie;
      logic             inv;
      logic             oe;
   } pin_cfg_t;

   function automatic logic [WORD_W-1:0] cfg_to_word(input pin_cfg_t c);
      logic [WORD_W-1:0] w;
      w = '0;
      w[FB_OE]                 = c.oe;
      w[FB_INV]                = c.inv;
      w[FB_IE]                 = c.ie;
      w[FB_SEL +: SEL_W]       = c.sel;
      return w;
   endfunction

   function automatic pin_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
      pin_cfg_t c;
      c.oe  = w[FB_OE];
      c.inv = w[FB_INV];
      c.ie  = w[FB_IE];
      c.sel = w[FB_SEL +: SEL_W];
      return c;
   endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS = 72,
   localparam int unsigned NGROUP  = (NUM_PINS + GROUP_W - 1) / GROUP_W,
   localparam int unsigned PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_t         kind,
   output logic              group,
   output logic [PIN_W-1:0]  pin
);

   localparam int unsigned CFG_END = OFS_CFG + 8 * NUM_PINS;

   int unsigned off;
   int unsigned rel;

   always_comb begin
      kind  = ACC_NONE;
      group = 1'b0;
      pin   = '0;
      off   = 32'(addr);
      rel   = 0;
      if (off == OFS_RX)       kind = ACC_RX;
      else if (off == OFS_SET) kind = ACC_SET;
      else if (off == OFS_CLR) kind = ACC_CLR;
      else if (off == OFS_CNT) kind = ACC_CNT;
      else if (NGROUP > 1 && off == OFS_HI + OFS_RX) begin
         kind  = ACC_RX;
         group = 1'b1;
      end
      else if (NGROUP > 1 && off == OFS_HI + OFS_SET) begin
         kind  = ACC_SET;
         group = 1'b1;
      end
      else if (NGROUP > 1 && off == OFS_HI + OFS_CLR) begin
         kind  = ACC_CLR;
         group = 1'b1;
      end
      else if (off >= OFS_CFG && off < CFG_END && addr[2:0] == 3'b000) begin
         kind = ACC_CFG;
         rel  = (off - OFS_CFG) >> 3;
         pin  = PIN_W'(rel);
      end
   end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS = 72,
   localparam int unsigned PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [PIN_W-1:0]    wr_pin,
   input  logic [WORD_W-1:0]   wr_word,
   input  logic [PIN_W-1:0]    rd_pin,
   output logic [WORD_W-1:0]   rd_word,
   output logic [NUM_PINS-1:0] oe_vec,
   output logic [NUM_PINS-1:0] inv_vec,
   output logic [NUM_PINS-1:0] ie_vec,
   output logic [NUM_PINS-1:0] owned_vec
);

   pin_cfg_t cfg_q [NUM_PINS];
   pin_cfg_t wr_cfg;

   assign wr_cfg = word_to_cfg(wr_word);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic hit;
      assign hit = wr_en && (32'(wr_pin) == p);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cfg_q[p] <= '0;
         else if (hit) cfg_q[p] <= wr_cfg;
      end

      assign oe_vec[p]    = cfg_q[p].oe;
      assign inv_vec[p]   = cfg_q[p].inv;
      assign ie_vec[p]    = cfg_q[p].ie;
      assign owned_vec[p] = (cfg_q[p].sel == '0);
   end

   always_comb begin
      rd_word = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (32'(rd_pin) == p) rd_word = cfg_to_word(cfg_q[p]);
      end
   end

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
   parameter int unsigned NUM_PINS    = 72,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pad_in,
   input  logic [NUM_PINS-1:0] inv_vec,
   output logic [NUM_PINS-1:0] rx_vec
);

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("gpio_insync: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= pad_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_fix
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rx_vec[p] <= 1'b0;
         else        rx_vec[p] <= stage_q[SYNC_STAGES-1][p] ^ inv_vec[p];
      end
   end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int unsigned WIDTH = 72
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_mask,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q | set_mask) & ~clr_mask;
   end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 72,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [12:0]         bus_addr,
   input  logic [63:0]         bus_wdata,
   output logic [63:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq
);

   localparam int unsigned NGROUP = (NUM_PINS + GROUP_W - 1) / GROUP_W;
   localparam int unsigned PADW   = NGROUP * GROUP_W;
   localparam int unsigned PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   if (NUM_PINS < 1 || NUM_PINS > 2 * GROUP_W) begin : g_bad_pins
      $error("gpio_regbank: NUM_PINS must lie in 1..128");
   end

   acc_kind_t           dec_kind;
   logic                dec_group;
   logic [PIN_W-1:0]    dec_pin;
   logic                do_wr;
   logic                do_rd;
   logic [PADW-1:0]     wd_spread;
   logic [NUM_PINS-1:0] set_mask;
   logic [NUM_PINS-1:0] clr_mask;
   logic [NUM_PINS-1:0] out_q;
   logic [NUM_PINS-1:0] rx_vec;
   logic [NUM_PINS-1:0] oe_vec;
   logic [NUM_PINS-1:0] inv_vec;
   logic [NUM_PINS-1:0] ie_vec;
   logic [NUM_PINS-1:0] owned_vec;
   logic [WORD_W-1:0]   cfg_word;
   logic [PADW-1:0]     rx_pad;
   logic [PADW-1:0]     out_pad;
   logic [WORD_W-1:0]   rx_words  [NGROUP];
   logic [WORD_W-1:0]   out_words [NGROUP];
   logic [WORD_W-1:0]   rx_sel;
   logic [WORD_W-1:0]   out_sel;
   logic [WORD_W-1:0]   rd_next;
   logic [WORD_W-1:0]   rdata_q;

   assign do_wr = bus_valid && bus_write;
   assign do_rd = bus_valid && !bus_write;

   gpio_addr_dec #(.NUM_PINS(NUM_PINS)) u_dec (
      .addr  (bus_addr),
      .kind  (dec_kind),
      .group (dec_group),
      .pin   (dec_pin)
   );

   for (genvar g = 0; g < NGROUP; g++) begin : g_group
      assign wd_spread[g*GROUP_W +: GROUP_W] =
         (32'(dec_group) == g) ? bus_wdata : '0;
      assign rx_words[g]  = rx_pad[g*GROUP_W +: GROUP_W];
      assign out_words[g] = out_pad[g*GROUP_W +: GROUP_W];
   end

   assign set_mask = (do_wr && dec_kind == ACC_SET) ? NUM_PINS'(wd_spread) : '0;
   assign clr_mask = (do_wr && dec_kind == ACC_CLR) ? NUM_PINS'(wd_spread) : '0;

   gpio_out_latch #(.WIDTH(NUM_PINS)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .q        (out_q)
   );

   gpio_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (do_wr && dec_kind == ACC_CFG),
      .wr_pin    (dec_pin),
      .wr_word   (bus_wdata),
      .rd_pin    (dec_pin),
      .rd_word   (cfg_word),
      .oe_vec    (oe_vec),
      .inv_vec   (inv_vec),
      .ie_vec    (ie_vec),
      .owned_vec (owned_vec)
   );

   gpio_insync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pad_in  (pad_in),
      .inv_vec (inv_vec),
      .rx_vec  (rx_vec)
   );

   assign rx_pad  = PADW'(rx_vec);
   assign out_pad = PADW'(out_q);

   always_comb begin
      rx_sel  = '0;
      out_sel = '0;
      for (int g = 0; g < NGROUP; g++) begin
         if (32'(dec_group) == g) begin
            rx_sel  = rx_words[g];
            out_sel = out_words[g];
         end
      end
   end

   always_comb begin
      unique case (dec_kind)
         ACC_RX:           rd_next = rx_sel;
         ACC_SET, ACC_CLR: rd_next = out_sel;
         ACC_CNT:          rd_next = WORD_W'(NUM_PINS);
         ACC_CFG:          rd_next = cfg_word;
         default:          rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (do_rd) rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;
   assign pad_out   = out_q;
   assign pad_oe    = oe_vec & owned_vec;
   assign irq       = |(rx_vec & ie_vec);

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int unsigned NUM_PINS = 72
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_valid,
   input logic                bus_write,
   input logic [12:0]         bus_addr,
   input logic [63:0]         bus_wdata,
   input logic [63:0]         bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic                irq
);

   localparam logic [63:0] LO_MASK =
      (NUM_PINS >= 64) ? {64{1'b1}} : ((64'd1 << NUM_PINS) - 64'd1);

   logic [127:0] out_ext;
   logic [63:0]  out_lo;
   logic         wr_set0;
   logic         wr_clr0;
   logic         wr_ro;
   logic         rd_cnt;

   assign out_ext = 128'(pad_out);
   assign out_lo  = out_ext[63:0];
   assign wr_set0 = bus_valid && bus_write && bus_addr == 13'h008;
   assign wr_clr0 = bus_valid && bus_write && bus_addr == 13'h010;
   assign wr_ro   = bus_valid && bus_write &&
                    (bus_addr == 13'h000 || bus_addr == 13'h090);
   assign rd_cnt  = bus_valid && !bus_write && bus_addr == 13'h090;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (pad_out == '0 && pad_oe == '0 && !irq);
      end
   end

   p_set_drives_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set0 |=> ((out_lo & $past(bus_wdata & LO_MASK)) == $past(bus_wdata & LO_MASK)));

   p_set_spares_others_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set0 |=> ((out_lo & ~$past(bus_wdata)) == ($past(out_lo) & ~$past(bus_wdata))));

   p_clr_drives_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr0 |=> ((out_lo & $past(bus_wdata)) == 64'd0));

   p_clr_spares_others_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr0 |=> ((out_lo & ~$past(bus_wdata)) == ($past(out_lo) & ~$past(bus_wdata))));

   p_count_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt |=> (bus_rdata == 64'(NUM_PINS)));

   p_readonly_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ro |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind gpio_regbank gpio_regbank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq)
);

// File: tb/gpio_regbank_bench.sv
`timescale 1ns/1ps
module gpio_regbank_bench;

   localparam int NP = 72;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [12:0]   bus_addr = '0;
   logic [63:0]   bus_wdata = '0;
   logic [63:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;
   logic          irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   gpio_regbank #(.NUM_PINS(NP)) u_gpio_regbank (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // ---------------- reference model ----------------
   logic [127:0] pinmask;
   logic [127:0] m_out, m_oe, m_inv, m_ie, m_s1, m_s2, m_rx;
   int           m_sel [128];
   logic [63:0]  m_rdata;
   bit           m_pend;
   string        m_tag;

   initial pinmask = (128'd1 << NP) - 128'd1;

   function automatic logic [127:0] sel_nz();
      logic [127:0] v = '0;
      for (int p = 0; p < NP; p++) v[p] = (m_sel[p] != 0);
      return v;
   endfunction

   task automatic model_reset();
      m_out = '0; m_oe = '0; m_inv = '0; m_ie = '0;
      m_s1 = '0; m_s2 = '0; m_rx = '0; m_rdata = '0; m_pend = 0;
      for (int p = 0; p < 128; p++) m_sel[p] = 0;
   endtask

   task automatic model_step();
      int a;
      int grp;
      int p;
      logic [63:0] rv;
      logic [127:0] wide;
      string tg;
      a = int'(bus_addr);
      grp = -1;
      rv = '0;
      tg = "R10";
      if (a == 'h0 || a == 'h8 || a == 'h10) grp = 0;
      if (NP > 64 && (a == 'h1400 || a == 'h1408 || a == 'h1410)) grp = 1;
      if (bus_valid && !bus_write) begin
         if (grp >= 0 && (a & 'hff) == 0) begin
            rv = m_rx[grp*64 +: 64];
            tg = (grp == 1) ? "R11" : "R5";
         end else if (grp >= 0) begin
            rv = m_out[grp*64 +: 64];
            tg = "R4";
         end else if (a == 'h90) begin
            rv = 64'(NP);
            tg = "R6";
         end else if (a >= 'h400 && a < 'h400 + 8 * NP && a % 8 == 0) begin
            p = (a - 'h400) / 8;
            rv = '0;
            rv[0] = m_oe[p]; rv[1] = m_inv[p]; rv[2] = m_ie[p];
            rv[26:16] = 11'(m_sel[p]);
            tg = "R7";
         end
      end
      // input pipeline uses pre-edge inversion
      m_rx = (m_s2 ^ m_inv) & pinmask;
      m_s2 = m_s1;
      m_s1 = 128'(pad_in) & pinmask;
      if (bus_valid && bus_write) begin
         wide = '0;
         if (grp >= 0) wide[grp*64 +: 64] = bus_wdata;
         wide &= pinmask;
         if (grp >= 0 && (a & 'hff) == 'h08) m_out |= wide;
         if (grp >= 0 && (a & 'hff) == 'h10) m_out &= ~wide;
         if (a >= 'h400 && a < 'h400 + 8 * NP && a % 8 == 0) begin
            p = (a - 'h400) / 8;
            m_oe[p]  = bus_wdata[0];
            m_inv[p] = bus_wdata[1];
            m_ie[p]  = bus_wdata[2];
            m_sel[p] = int'(bus_wdata[26:16]);
         end
      end
      if (bus_valid && !bus_write) begin
         m_rdata = rv;
         m_pend = 1;
         m_tag = tg;
      end else begin
         m_pend = 0;
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else        model_step();
   end

   // ---------------- checking ----------------
   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [127:0] exp_oe;
      logic         exp_irq;
      if (!rst_n) begin
         check(pad_out == '0 && pad_oe == '0 && !irq, "R1 reset outputs",
               {pad_out, pad_oe, irq}, '0);
         return;
      end
      exp_oe  = m_oe & ~sel_nz() & pinmask;
      exp_irq = |(m_rx & m_ie);
      check(128'(pad_out) == m_out, "R2 R3 pad_out", 128'(pad_out), m_out);
      check(128'(pad_oe) == exp_oe, "R8 pad_oe", 128'(pad_oe), exp_oe);
      check(irq == exp_irq, "R9 irq", 128'(irq), 128'(exp_irq));
      if (m_pend)
         check(bus_rdata == m_rdata, {m_tag, " read data"}, 128'(bus_rdata),
               128'(m_rdata));
   endtask

   task automatic op(input bit v, input bit w, input int a, input logic [63:0] d);
      @(negedge clk);
      compare();
      bus_valid = v;
      bus_write = w;
      bus_addr  = 13'(a);
      bus_wdata = d;
   endtask

   task automatic wr(input int a, input logic [63:0] d); op(1, 1, a, d); endtask
   task automatic rd(input int a); op(1, 0, a, '0); endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(0, 0, 0, '0);
   endtask

   function automatic logic [63:0] cfgw(input bit oe, input bit inv, input bit ie,
                                        input int sel);
      logic [63:0] w = '0;
      w[0] = oe; w[1] = inv; w[2] = ie; w[26:16] = 11'(sel);
      return w;
   endfunction

   initial begin
      // R1: reset state
      repeat (3) begin @(negedge clk); compare(); end
      @(negedge clk); rst_n = 1'b1;
      rd('h400); rd('h400 + 8 * 71); idle(1);

      // R2 R3: set/clear patterns, R4 readback
      wr('h008, 64'hF0F0_0000_0000_00FF);
      rd('h008);
      wr('h010, 64'h0000_0000_0000_000F);
      rd('h010);
      wr('h008, 64'h0000_0000_0000_0000);
      wr('h010, 64'hF000_0000_0000_0000);
      wr('h008, 64'hFFFF_FFFF_FFFF_FFFF);
      wr('h010, 64'hAAAA_AAAA_AAAA_AAAA);
      rd('h008);

      // R11: second group
      wr('h1408, 64'h0000_0000_0000_01FF);
      rd('h1408);
      wr('h1410, 64'h0000_0000_0000_0055);
      rd('h1410);
      pad_in = {8'hA5, 64'h1234_5678_9ABC_DEF0};
      idle(4);
      rd('h1400); rd('h0000);

      // R7 R8: config fields and ownership
      wr('h400 + 8 * 0, cfgw(1, 0, 0, 0));
      wr('h400 + 8 * 1, cfgw(1, 0, 0, 5));
      wr('h400 + 8 * 70, cfgw(1, 1, 1, 11'h7FF));
      wr('h400 + 8 * 3, 64'hFFFF_FFFF_FFFF_FFFF);
      rd('h400 + 8 * 3); rd('h400 + 8 * 70); rd('h400 + 8 * 1);
      wr('h400 + 8 * 1, cfgw(1, 0, 0, 0));
      idle(1);

      // R5 R9: inversion and interrupt latency
      pad_in = '0;
      idle(4);
      wr('h400 + 8 * 5, cfgw(0, 0, 1, 0));
      pad_in[5] = 1'b1;
      idle(1); rd('h0); idle(1); rd('h0); idle(2);
      wr('h400 + 8 * 5, cfgw(0, 1, 1, 0));
      rd('h0); idle(2);
      wr('h400 + 8 * 5, cfgw(0, 0, 0, 0));
      idle(2);

      // R6 R10: count, unmapped, misaligned, read-only writes
      rd('h090);
      wr('h090, 64'hFFFF);
      wr('h000, 64'hFFFF_FFFF_FFFF_FFFF);
      wr('h018, 64'hFFFF_FFFF_FFFF_FFFF);
      wr('h404, 64'hFFFF_FFFF_FFFF_FFFF);
      wr('h400 + 8 * NP, 64'hFFFF_FFFF_FFFF_FFFF);
      wr('h1490, 64'hFFFF_FFFF_FFFF_FFFF);
      rd('h090); rd('h018); rd('h404); rd('h400 + 8 * NP); rd('h1418);
      rd('h1490); rd('h098); rd('h00C);

      // mixed traffic
      for (int i = 0; i < 3000; i++) begin
         int pick;
         int a;
         logic [63:0] d;
         pick = $urandom_range(0, 13);
         d = {$urandom, $urandom};
         case (pick)
            0: a = 'h0;
            1: a = 'h8;
            2: a = 'h10;
            3: a = 'h90;
            4: a = 'h1400;
            5: a = 'h1408;
            6: a = 'h1410;
            7: a = 'h18;
            8: a = 'h404 + 8 * $urandom_range(0, NP - 1);
            9: a = 'h1418;
            default: a = 'h400 + 8 * $urandom_range(0, NP + 1);
         endcase
         if ($urandom_range(0, 3) == 0)
            pad_in = NP'({$urandom, $urandom, $urandom});
         case ($urandom_range(0, 2))
            0: wr(a, d);
            1: rd(a);
            default: idle(1);
         endcase
      end
      idle(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule